// File: doc/BRIEF.md
# Early Load Address Generator

This block sits beside the decode stage and watches each decoded instruction for the short sequences that build an address in a general register. Those sequences are a low-constant load, a high-constant load and a register add. For each such instruction it keeps a speculative copy of the result, tagged with the destination register number. It assumes that a load will follow at once.

When the next decoded instruction is a load whose address register equals the tagged register, the block sends the copied address to the translation unit. The resulting physical address is then ready at the start of the load's execute cycle, one cycle earlier than the normal path. If translation misses or faults, the guess is dropped and the load falls back to the normal-latency path. A flush, or an unrelated write to the tracked register, invalidates the copy.

Top module: `elag_top`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `xlat_req_valid` and `pred_valid` are low.
- R2: Opcode 1 (low constant) sets the tracked value to the 16-bit immediate with zero extension. The tag becomes `instr_dst`.
- R3: Opcode 2 (high constant) puts the immediate into bits 31:16. Bits 15:0 come from the tracked value if the tracked copy is valid and its tag equals `instr_dst`; otherwise they come from `opnd_a[15:0]`.
- R4: Opcode 3 (add) sets the tracked value to `opnd_a + opnd_b` modulo 2^32, tagged with `instr_dst`.
- R5: Opcode 4 (load) raises a translation request only when the previous valid instruction was an opcode 1, 2 or 3. Cycles with `instr_valid` low do not break this adjacency, and any other valid instruction in between does.
- R6: A load whose `instr_areg` differs from the tag raises no request.
- R7: A valid instruction that is not an opcode 1, 2 or 3 invalidates the copy if it has `instr_wr_en` high and its `instr_dst` equals the tag. Opcodes 0 and 5 to 7 are such instructions, and so is opcode 4. A following high constant to that register then takes its low half from `opnd_a`.
- R8: `flush` discards the instruction of that cycle and invalidates the copy. No prediction appears in the cycle after a flush.
- R9: A matching load in cycle N gives `xlat_req_valid` high in cycle N+1, with `xlat_vaddr` holding the tracked value. On a translation hit without fault in N+1, `pred_valid` is high in N+2 with `pred_paddr` equal to the `xlat_paddr` of N+1.
- R10: A translation miss (`xlat_hit` low) or a fault (`xlat_fault` high) in the request cycle gives no prediction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Pipeline flush |
| instr_valid | input | 1 | Decoded instruction present |
| instr_op | input | 3 | Opcode class: 0 other, 1 low constant, 2 high constant, 3 add, 4 load |
| instr_dst | input | 8 | Destination register number |
| instr_areg | input | 8 | Load address register number |
| instr_imm | input | 16 | Immediate of constant instructions |
| instr_wr_en | input | 1 | Instruction of class 0 or 4 writes `instr_dst` |
| opnd_a | input | 32 | First register operand value |
| opnd_b | input | 32 | Second register operand value |
| xlat_req_valid | output | 1 | Translation request |
| xlat_vaddr | output | 32 | Virtual address to translate |
| xlat_hit | input | 1 | Translation hit, sampled in the request cycle |
| xlat_fault | input | 1 | Translation fault, sampled in the request cycle |
| xlat_paddr | input | 32 | Translated physical address |
| pred_valid | output | 1 | Early physical load address valid |
| pred_paddr | output | 32 | Early physical load address |

## Verification
Directed sequences each build an address by one route: a lone low constant, a low/high pair on one register, a high constant on an untracked register, and an add that wraps. Comparing the requested address across these routes separates the zero-extension, half-merge and modular-sum paths. Further patterns place a bubble, an unrelated instruction or a different address register between producer and load, which separates adjacency from register matching. Translation responses chosen by address bits show whether misses, faults and flushes each suppress the prediction. Long random streams biased toward producer/load pairs then compare every request and prediction against a bench model.

// File: rtl/elag_pkg.sv
package elag_pkg;
  typedef enum logic [2:0] {
    OPC_MISC  = 3'd0,
    OPC_LOLIT = 3'd1,
    OPC_HILIT = 3'd2,
    OPC_SUM   = 3'd3,
    OPC_LOAD  = 3'd4
  } opc_e;

  typedef struct packed {
    logic is_lo;
    logic is_hi;
    logic is_sum;
    logic is_load;
    logic is_other;
    logic other_wr;
  } cls_t;
endpackage

// File: rtl/elag_classify.sv
module elag_classify
  import elag_pkg::*;
(
  input  logic       instr_valid,
  input  logic       flush,
  input  logic [2:0] instr_op,
  input  logic       instr_wr_en,
  output cls_t       cls
);
  logic live;
  assign live = instr_valid && !flush;

  always_comb begin
    cls = '0;
    if (live) begin
      case (instr_op)
        OPC_LOLIT: cls.is_lo  = 1'b1;
        OPC_HILIT: cls.is_hi  = 1'b1;
        OPC_SUM:   cls.is_sum = 1'b1;
        default:   cls.is_other = 1'b1;
      endcase
      cls.is_load  = (instr_op == OPC_LOAD);
      cls.other_wr = cls.is_other && instr_wr_en;
    end
  end
endmodule

// File: rtl/elag_tracker.sv
module elag_tracker
  import elag_pkg::*;
#(
  parameter int RW = 8,
  parameter int AW = 32,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  cls_t          cls,
  input  logic [RW-1:0] instr_dst,
  input  logic [IW-1:0] instr_imm,
  input  logic [AW-1:0] opnd_a,
  input  logic [AW-1:0] opnd_b,
  output logic          trk_valid,
  output logic          trk_fresh,
  output logic [RW-1:0] trk_tag,
  output logic [AW-1:0] trk_value
);
  localparam int LOW_W = AW - IW;

  logic          producer;
  logic          same_reg;
  logic [LOW_W-1:0] low_keep;
  logic [AW-1:0] next_value;

  assign producer = cls.is_lo || cls.is_hi || cls.is_sum;
  assign same_reg = trk_valid && (trk_tag == instr_dst);
  assign low_keep = same_reg ? trk_value[LOW_W-1:0] : opnd_a[LOW_W-1:0];

  always_comb begin
    next_value = opnd_a + opnd_b;
    if (cls.is_lo)
      next_value = {{LOW_W{1'b0}}, instr_imm};
    else if (cls.is_hi)
      next_value = {instr_imm, low_keep};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trk_valid <= 1'b0;
      trk_fresh <= 1'b0;
      trk_tag   <= '0;
      trk_value <= '0;
    end else if (flush) begin
      trk_valid <= 1'b0;
      trk_fresh <= 1'b0;
    end else if (producer) begin
      trk_valid <= 1'b1;
      trk_fresh <= 1'b1;
      trk_tag   <= instr_dst;
      trk_value <= next_value;
    end else if (cls.is_other) begin
      trk_fresh <= 1'b0;
      if (cls.other_wr && same_reg)
        trk_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/elag_issue.sv
module elag_issue
  import elag_pkg::*;
#(
  parameter int RW = 8,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  cls_t          cls,
  input  logic [RW-1:0] instr_areg,
  input  logic          trk_valid,
  input  logic          trk_fresh,
  input  logic [RW-1:0] trk_tag,
  input  logic [AW-1:0] trk_value,
  input  logic          xlat_hit,
  input  logic          xlat_fault,
  input  logic [AW-1:0] xlat_paddr,
  output logic          xlat_req_valid,
  output logic [AW-1:0] xlat_vaddr,
  output logic          pred_valid,
  output logic [AW-1:0] pred_paddr
);
  logic load_match;
  logic take;

  assign load_match = cls.is_load && trk_fresh && trk_valid && (instr_areg == trk_tag);
  assign take       = xlat_req_valid && xlat_hit && !xlat_fault && !flush;

  always_ff @(posedge clk) begin
    if (rst) begin
      xlat_req_valid <= 1'b0;
      xlat_vaddr     <= '0;
      pred_valid     <= 1'b0;
      pred_paddr     <= '0;
    end else begin
      xlat_req_valid <= load_match;
      if (load_match)
        xlat_vaddr <= trk_value;
      pred_valid <= take;
      if (take)
        pred_paddr <= xlat_paddr;
    end
  end
endmodule

// File: rtl/elag_top.sv
module elag_top
  import elag_pkg::*;
#(
  parameter int RW = 8,
  parameter int AW = 32,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          instr_valid,
  input  logic [2:0]    instr_op,
  input  logic [RW-1:0] instr_dst,
  input  logic [RW-1:0] instr_areg,
  input  logic [IW-1:0] instr_imm,
  input  logic          instr_wr_en,
  input  logic [AW-1:0] opnd_a,
  input  logic [AW-1:0] opnd_b,
  output logic          xlat_req_valid,
  output logic [AW-1:0] xlat_vaddr,
  input  logic          xlat_hit,
  input  logic          xlat_fault,
  input  logic [AW-1:0] xlat_paddr,
  output logic          pred_valid,
  output logic [AW-1:0] pred_paddr
);
  cls_t          cls;
  logic          trk_valid;
  logic          trk_fresh;
  logic [RW-1:0] trk_tag;
  logic [AW-1:0] trk_value;

  elag_classify u_cls (
    .instr_valid (instr_valid),
    .flush       (flush),
    .instr_op    (instr_op),
    .instr_wr_en (instr_wr_en),
    .cls         (cls)
  );

  elag_tracker #(.RW(RW), .AW(AW), .IW(IW)) u_trk (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .cls       (cls),
    .instr_dst (instr_dst),
    .instr_imm (instr_imm),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .trk_valid (trk_valid),
    .trk_fresh (trk_fresh),
    .trk_tag   (trk_tag),
    .trk_value (trk_value)
  );

  elag_issue #(.RW(RW), .AW(AW)) u_iss (
    .clk            (clk),
    .rst            (rst),
    .flush          (flush),
    .cls            (cls),
    .instr_areg     (instr_areg),
    .trk_valid      (trk_valid),
    .trk_fresh      (trk_fresh),
    .trk_tag        (trk_tag),
    .trk_value      (trk_value),
    .xlat_hit       (xlat_hit),
    .xlat_fault     (xlat_fault),
    .xlat_paddr     (xlat_paddr),
    .xlat_req_valid (xlat_req_valid),
    .xlat_vaddr     (xlat_vaddr),
    .pred_valid     (pred_valid),
    .pred_paddr     (pred_paddr)
  );
endmodule

// File: rtl/elag_chk.sv
module elag_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          flush,
  input logic          instr_valid,
  input logic [2:0]    instr_op,
  input logic          xlat_req_valid,
  input logic          xlat_hit,
  input logic          xlat_fault,
  input logic [AW-1:0] xlat_paddr,
  input logic          pred_valid,
  input logic [AW-1:0] pred_paddr
);
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !xlat_req_valid && !pred_valid); // R1
  AST_REQ_FROM_LOAD: assert property (@(posedge clk) disable iff (rst)
    xlat_req_valid |-> $past(instr_valid && !flush && instr_op == 3'd4)); // R5
  AST_FLUSH_NO_PRED: assert property (@(posedge clk) disable iff (rst)
    flush |=> !pred_valid && !xlat_req_valid); // R8
  AST_PRED_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    pred_valid |-> $past(xlat_req_valid) && pred_paddr == $past(xlat_paddr)); // R9
  AST_MISS_DROPS: assert property (@(posedge clk) disable iff (rst)
    xlat_req_valid && (!xlat_hit || xlat_fault) |=> !pred_valid); // R10
endmodule

bind elag_top elag_chk #(.AW(AW)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .flush          (flush),
  .instr_valid    (instr_valid),
  .instr_op       (instr_op),
  .xlat_req_valid (xlat_req_valid),
  .xlat_hit       (xlat_hit),
  .xlat_fault     (xlat_fault),
  .xlat_paddr     (xlat_paddr),
  .pred_valid     (pred_valid),
  .pred_paddr     (pred_paddr)
);

// File: tb/sim_elag_top.sv
module sim_elag_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0;
  logic        instr_valid = 1'b0;
  logic [2:0]  instr_op = 3'd0;
  logic [7:0]  instr_dst = 8'd0;
  logic [7:0]  instr_areg = 8'd0;
  logic [15:0] instr_imm = 16'd0;
  logic        instr_wr_en = 1'b0;
  logic [31:0] opnd_a = 32'd0;
  logic [31:0] opnd_b = 32'd0;
  logic        xlat_hit = 1'b0;
  logic        xlat_fault = 1'b0;
  logic [31:0] xlat_paddr = 32'd0;
  logic        xlat_req_valid;
  logic [31:0] xlat_vaddr;
  logic        pred_valid;
  logic [31:0] pred_paddr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model
  bit          m_valid = 0, m_fresh = 0;
  logic [7:0]  m_tag = 0;
  logic [31:0] m_val = 0;
  bit          e_req = 0, e_pred = 0;
  logic [31:0] e_vaddr = 0, e_paddr = 0;

  always #5 clk = ~clk;

  elag_top u0 (.*);

  function automatic logic [31:0] map_addr(input logic [31:0] v);
    return v ^ 32'h5A5A_0000 ^ {v[15:0], 16'h0};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [2:0] op, input logic [7:0] dst, input logic [7:0] areg,
                      input logic [15:0] imm, input logic [31:0] a, input logic [31:0] b,
                      input bit wr, input bit fl, input string req);
    bit hit, flt, match, prod;
    logic [31:0] pa, nv;
    @(negedge clk);
    chk(xlat_req_valid == e_req && (!e_req || xlat_vaddr == e_vaddr), req,
        {xlat_req_valid, xlat_vaddr[30:0]}, {e_req, e_vaddr[30:0]});
    chk(pred_valid == e_pred && (!e_pred || pred_paddr == e_paddr), req,
        {pred_valid, pred_paddr[30:0]}, {e_pred, e_paddr[30:0]});
    hit = xlat_vaddr[3:0] != 4'hF;
    flt = xlat_vaddr[7:4] == 4'hE;
    pa  = map_addr(xlat_vaddr);
    xlat_hit = hit; xlat_fault = flt; xlat_paddr = pa;
    instr_valid = v; instr_op = op; instr_dst = dst; instr_areg = areg;
    instr_imm = imm; opnd_a = a; opnd_b = b; instr_wr_en = wr; flush = fl;
    // next expectations
    e_pred  = e_req && hit && !flt && !fl;
    if (e_pred) e_paddr = pa;
    match = v && !fl && op == 3'd4 && m_fresh && m_valid && areg == m_tag;
    if (match) e_vaddr = m_val;
    e_req = match;
    prod = op == 3'd1 || op == 3'd2 || op == 3'd3;
    if (fl) begin
      m_valid = 0; m_fresh = 0;
    end else if (v && prod) begin
      if (op == 3'd1) nv = {16'h0, imm};
      else if (op == 3'd2) nv = {imm, (m_valid && m_tag == dst) ? m_val[15:0] : a[15:0]};
      else nv = a + b;
      m_val = nv; m_tag = dst; m_valid = 1; m_fresh = 1;
    end else if (v) begin
      m_fresh = 0;
      if (wr && dst == m_tag) m_valid = 0;
    end
  endtask

  task automatic idle(input string req);
    step(0, 3'd0, 8'd0, 8'd0, 16'd0, 32'd0, 32'd0, 0, 0, req);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!xlat_req_valid && !pred_valid, "R1", {xlat_req_valid, pred_valid}, 0);
    rst = 1'b0;
    idle("R1");
    // R2: low constant then load
    step(1, 3'd1, 8'd5, 0, 16'h1234, 0, 0, 0, 0, "R2");
    step(1, 3'd4, 8'd9, 8'd5, 0, 0, 0, 1, 0, "R2");
    idle("R2"); idle("R9");
    // R3: low/high pair on one register, then high on untracked register
    step(1, 3'd1, 8'd5, 0, 16'h1234, 0, 0, 0, 0, "R3");
    step(1, 3'd2, 8'd5, 0, 16'hABCD, 32'hFFFF_0000, 0, 0, 0, "R3");
    step(1, 3'd4, 8'd9, 8'd5, 0, 0, 0, 1, 0, "R3");
    idle("R3"); idle("R9");
    step(1, 3'd2, 8'd7, 0, 16'hBEEF, 32'h1111_2222, 0, 0, 0, "R3");
    step(1, 3'd4, 8'd9, 8'd7, 0, 0, 0, 1, 0, "R3");
    idle("R3"); idle("R3");
    // R4: add wrapping
    step(1, 3'd3, 8'd9, 0, 0, 32'hFFFF_FFF0, 32'h0000_0022, 0, 0, "R4");
    step(1, 3'd4, 8'd1, 8'd9, 0, 0, 0, 1, 0, "R4");
    idle("R4"); idle("R4");
    // R5: bubble keeps adjacency, other instruction breaks it
    step(1, 3'd1, 8'd3, 0, 16'h0040, 0, 0, 0, 0, "R5");
    idle("R5");
    step(1, 3'd4, 8'd2, 8'd3, 0, 0, 0, 1, 0, "R5");
    idle("R5"); idle("R5");
    step(1, 3'd1, 8'd3, 0, 16'h0050, 0, 0, 0, 0, "R5");
    step(1, 3'd0, 8'd20, 0, 0, 0, 0, 1, 0, "R5");
    step(1, 3'd4, 8'd2, 8'd3, 0, 0, 0, 1, 0, "R5");
    idle("R5"); idle("R5");
    // R6: different address register
    step(1, 3'd1, 8'd3, 0, 16'h0060, 0, 0, 0, 0, "R6");
    step(1, 3'd4, 8'd2, 8'd4, 0, 0, 0, 1, 0, "R6");
    idle("R6"); idle("R6");
    // R7: other write to tracked register, then high constant
    step(1, 3'd1, 8'd6, 0, 16'h9999, 0, 0, 0, 0, "R7");
    step(1, 3'd0, 8'd6, 0, 0, 0, 0, 1, 0, "R7");
    step(1, 3'd2, 8'd6, 0, 16'h4321, 32'h0000_7777, 0, 0, 0, "R7");
    step(1, 3'd4, 8'd2, 8'd6, 0, 0, 0, 1, 0, "R7");
    idle("R7"); idle("R7");
    // R8: flush on load, flush during request
    step(1, 3'd1, 8'd2, 0, 16'h0070, 0, 0, 0, 0, "R8");
    step(1, 3'd4, 8'd1, 8'd2, 0, 0, 0, 1, 1, "R8");
    idle("R8"); idle("R8");
    step(1, 3'd1, 8'd2, 0, 16'h0080, 0, 0, 0, 0, "R8");
    step(1, 3'd4, 8'd1, 8'd2, 0, 0, 0, 1, 0, "R8");
    step(0, 3'd0, 0, 0, 0, 0, 0, 0, 1, "R8");
    idle("R8"); idle("R8");
    // R10: miss and fault
    step(1, 3'd1, 8'd1, 0, 16'h000F, 0, 0, 0, 0, "R10");
    step(1, 3'd4, 8'd3, 8'd1, 0, 0, 0, 1, 0, "R10");
    idle("R10"); idle("R10");
    step(1, 3'd1, 8'd1, 0, 16'h00E0, 0, 0, 0, 0, "R10");
    step(1, 3'd4, 8'd3, 8'd1, 0, 0, 0, 1, 0, "R10");
    idle("R10"); idle("R10");
    // random mix, checked by the model (R9)
    for (int i = 0; i < 4000; i++) begin
      int sel = $urandom_range(0, 9);
      logic [7:0] r = 8'($urandom_range(0, 3));
      logic [2:0] op = (sel < 2) ? 3'd1 : (sel < 3) ? 3'd2 : (sel < 4) ? 3'd3 :
                       (sel < 8) ? 3'd4 : 3'($urandom_range(5, 7));
      step($urandom_range(0, 7) != 0, op, r, (sel < 7) ? m_tag : r, 16'($urandom),
           $urandom, $urandom, 1'($urandom), $urandom_range(0, 31) == 0, "R9");
    end
    idle("R9"); idle("R9");
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule